// File: doc/BRIEF.md
# External Address Output Unit with Selectable Update Mode

This block owns the external address pins and the active-low read strobe of a microcontroller bus interface. Each accepted bus request carries an address, a flag that says whether it targets external or internal space (on-chip memory or internal I/O), an access size (byte or word), a read/write flag, and the data width of the external area it falls in. The block turns every request into one bus cycle of `CYC_LEN` clocks. A word access to an 8-bit external area becomes two back-to-back byte cycles.

Two address update policies are available. In the follow-every-cycle policy, the external address register takes the new address at the start of every bus cycle, whatever the target. In the external-only policy, the register is loaded only by external cycles. An on-chip cycle that follows an external read therefore leaves the external address steady, well past the read strobe's release, and internal addresses never reach the pins. One mode bit in a control register, mapped into internal I/O space, picks the policy. After reset the follow-every-cycle policy is active.

Top module: `ext_addr_unit`

## Requirements
- R1: After reset, `ext_addr` is 0, `rd_n` is 1, `req_ready` is 1 and `reg_rdata` is 0xFF, so the follow-every-cycle policy is active.
- R2: When `reg_rdata[0]` is 1 (follow-every-cycle), every accepted request loads `ext_addr` with its cycle address on the clock edge that accepts it. This holds for internal and external targets alike.
- R3: When `reg_rdata[0]` is 0 (external-only), only requests with `req_ext`=1 load `ext_addr`. Internal requests leave `ext_addr` unchanged for their whole cycle and after it.
- R4: An internal (`req_ext`=0) write to `CTRL_ADDR` (default 0xFEE01E) copies `req_wdata[0]` into the mode bit: 1 selects follow-every-cycle, 0 selects external-only. `reg_rdata[7:1]` always reads 1. An external write to the same address leaves the register unchanged.
- R5: For an external read, `rd_n` is 0 from the accepting edge for `CYC_LEN`-1 clocks and returns to 1 in the last clock of the cycle. It stays 1 during internal cycles and external writes.
- R6: An external word access with `area_8bit`=1 runs as two cycles of `CYC_LEN` clocks each. The first drives the even address (bit 0 cleared) and the second drives the odd address (bit 0 set). For a read, `rd_n` pulses low in each half. The address changes between the halves in both modes.
- R7: A word access to a 16-bit external area is one cycle at the even address. A byte access is one cycle at its own address.
- R8: `req_ready` is 1 only when no cycle is in progress. After acceptance it drops for exactly `CYC_LEN` clocks, or `2*CYC_LEN` clocks for a split access, and then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge if valid |
| req_addr | input | AW | Byte address of the access |
| req_ext | input | 1 | 1 = external space, 0 = on-chip memory or internal I/O |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_wr | input | 1 | 1 = write, 0 = read |
| area_8bit | input | 1 | External area is 8 bits wide |
| req_wdata | input | 8 | Write data (bit 0 used by the control register) |
| ext_addr | output | AW | Registered external address pins |
| rd_n | output | 1 | Registered active-low read strobe |
| reg_rdata | output | 8 | Control register contents |

## Verification
The assertions assume that request fields are only meaningful together with `req_valid`, and that the mode seen at acceptance governs the whole cycle. The bench keeps to this by driving a complete request on a falling edge, holding it through exactly one accepting rising edge, and then dropping `req_valid` until `req_ready` returns. Random requests mix targets, sizes, directions and area widths freely. The only writes that touch the control register come from the directed steps, so mode switches happen at known points, and a reference model predicts the address and strobe on every clock.

// File: rtl/eau_pkg.sv
package eau_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} eau_state_e;

  // Cycle address of the first (or only) cycle: words start on the even byte.
  function automatic logic [63:0] first_addr(input logic [63:0] a, input logic word);
    return word ? {a[63:1], 1'b0} : a;
  endfunction
endpackage

// File: rtl/eau_cfg_reg.sv
module eau_cfg_reg #(
  parameter int AW = 24,
  parameter logic [AW-1:0] CTRL_ADDR = 24'hFEE01E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          req_ext,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic          wbit,
  output logic          mode1_q,
  output logic [7:0]    rdata
);
  logic hit;
  assign hit = acc && !req_ext && req_wr && (req_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst)      mode1_q <= 1'b1;
    else if (hit) mode1_q <= wbit;
  end

  assign rdata = {7'h7F, mode1_q};
endmodule

// File: rtl/eau_seq.sv
module eau_seq
  import eau_pkg::*;
#(
  parameter int CYC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic is_read,
  input  logic split,
  output logic ready,
  output logic rd_n,
  output logic second_go
);
  localparam int CW = (CYC_LEN > 2) ? $clog2(CYC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);
  localparam logic [CW-1:0] RISE = CW'(CYC_LEN - 2);

  eau_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          half_q, split_q, rdcyc_q, rd_q;
  logic          at_last;

  assign at_last   = (state_q == ST_BUSY) && (cnt_q == LAST);
  assign second_go = at_last && split_q && !half_q;
  assign ready     = (state_q == ST_IDLE);
  assign rd_n      = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      split_q <= 1'b0;
      rdcyc_q <= 1'b0;
      rd_q    <= 1'b1;
    end else if (state_q == ST_IDLE) begin
      if (acc) begin
        state_q <= ST_BUSY;
        cnt_q   <= '0;
        half_q  <= 1'b0;
        split_q <= split;
        rdcyc_q <= is_read;
        rd_q    <= !is_read;
      end
    end else if (at_last) begin
      if (second_go) begin
        half_q <= 1'b1;
        cnt_q  <= '0;
        rd_q   <= !rdcyc_q;
      end else begin
        state_q <= ST_IDLE;
        rd_q    <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == RISE) rd_q <= 1'b1;
    end
  end
endmodule

// File: rtl/eau_addr_out.sv
module eau_addr_out #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          load_first,
  input  logic          load_second,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] ext_addr
);
  logic [AW-1:0] odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr <= '0;
      odd_q    <= '0;
    end else begin
      if (acc)         odd_q    <= {req_addr[AW-1:1], 1'b1};
      if (load_first)  ext_addr <= first;
      else if (load_second) ext_addr <= odd_q;
    end
  end
endmodule

// File: rtl/ext_addr_unit.sv
module ext_addr_unit #(
  parameter int AW = 24,
  parameter int CYC_LEN = 2,
  parameter logic [AW-1:0] CTRL_ADDR = 24'hFEE01E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_ext,
  input  logic          req_word,
  input  logic          req_wr,
  input  logic          area_8bit,
  input  logic [7:0]    req_wdata,
  output logic [AW-1:0] ext_addr,
  output logic          rd_n,
  output logic [7:0]    reg_rdata
);
  import eau_pkg::*;

  logic          acc, mode1_q, second_go, split, is_read, load_first;
  logic [AW-1:0] first;

  assign acc        = req_valid && req_ready;
  assign split      = req_ext && req_word && area_8bit;
  assign is_read    = req_ext && !req_wr;
  assign first      = AW'(first_addr(64'(req_addr), req_word));
  assign load_first = acc && (mode1_q || req_ext);

  eau_cfg_reg #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .acc(acc), .req_ext(req_ext), .req_wr(req_wr),
    .req_addr(req_addr), .wbit(req_wdata[0]), .mode1_q(mode1_q), .rdata(reg_rdata)
  );

  eau_seq #(.CYC_LEN(CYC_LEN)) u_seq (
    .clk(clk), .rst(rst), .acc(acc), .is_read(is_read), .split(split),
    .ready(req_ready), .rd_n(rd_n), .second_go(second_go)
  );

  eau_addr_out #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .acc(acc), .load_first(load_first),
    .load_second(second_go), .first(first), .req_addr(req_addr), .ext_addr(ext_addr)
  );
endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_ext,
  input logic          req_word,
  input logic          req_wr,
  input logic [AW-1:0] ext_addr,
  input logic          rd_n,
  input logic [7:0]    reg_rdata,
  input logic          mode1_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (rd_n && req_ready && reg_rdata == 8'hFF && ext_addr == '0));

  assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && mode1_q && !req_word) |=> ext_addr == $past(req_addr));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !mode1_q && !req_ext) |=> $stable(ext_addr));

  assert_fixed_bits_R4: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:1] == 7'h7F);

  assert_internal_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && !(req_ext && !req_wr)) |=> rd_n);

  assert_read_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && req_ext && !req_wr) |=> !rd_n);

  assert_even_first_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && req_ext && req_word) |=> !ext_addr[0]);

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    acc |=> !req_ready);
endmodule

bind ext_addr_unit eau_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_ext(req_ext), .req_word(req_word), .req_wr(req_wr),
  .ext_addr(ext_addr), .rd_n(rd_n), .reg_rdata(reg_rdata), .mode1_q(mode1_q)
);

// File: tb/sim_ext_addr_unit.sv
`timescale 1ns/1ps
module sim_ext_addr_unit;
  localparam int AW = 24;
  localparam int CYC = 2;
  localparam logic [AW-1:0] CTRL = 24'hFEE01E;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_ext = 1'b0, req_word = 1'b0, req_wr = 1'b0, area_8bit = 1'b0;
  logic [7:0]    req_wdata = '0;
  logic [AW-1:0] ext_addr;
  logic          rd_n;
  logic [7:0]    reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit m_mode1 = 1'b1;
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  ext_addr_unit #(.AW(AW), .CYC_LEN(CYC), .CTRL_ADDR(CTRL)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ext(req_ext), .req_word(req_word), .req_wr(req_wr),
    .area_8bit(area_8bit), .req_wdata(req_wdata), .ext_addr(ext_addr), .rd_n(rd_n),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] a, input bit ext, input bit word,
                         input bit wr, input bit a8, input logic [7:0] wd);
    bit split = ext && word && a8;
    bit rd = ext && !wr;
    logic [AW-1:0] first = word ? {a[AW-1:1], 1'b0} : a;
    string tag = split ? "R6" : ((ext && word) ? "R7" : (m_mode1 ? "R2" : "R3"));
    @(negedge clk);
    check("R8 idle ready", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_ext = ext; req_word = word;
    req_wr = wr; area_8bit = a8; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (m_mode1 || ext) m_addr = first;
    check(tag, 32'(ext_addr), 32'(m_addr));
    check("R5 strobe start", 32'(rd_n), 32'(!rd));
    check("R8 busy", 32'(req_ready), 32'd0);
    if (!ext && wr && a == CTRL) m_mode1 = wd[0];
    for (int k = 1; k < CYC; k++) @(negedge clk);
    check("R5 strobe release", 32'(rd_n), 32'd1);
    check(tag, 32'(ext_addr), 32'(m_addr));
    if (split) begin
      @(negedge clk);
      m_addr = {a[AW-1:1], 1'b1};
      check("R6 odd half addr", 32'(ext_addr), 32'(m_addr));
      check("R6 odd half strobe", 32'(rd_n), 32'(!rd));
      check("R8 busy split", 32'(req_ready), 32'd0);
      for (int k = 1; k < CYC; k++) @(negedge clk);
      check("R6 odd half release", 32'(rd_n), 32'd1);
    end
    @(negedge clk);
    check("R8 ready after cycle", 32'(req_ready), 32'd1);
    check(tag, 32'(ext_addr), 32'(m_addr));
    check("R4 register", 32'(reg_rdata), 32'({7'h7F, m_mode1}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 addr", 32'(ext_addr), 32'd0);
    check("R1 rd_n", 32'(rd_n), 32'd1);
    check("R1 ready", 32'(req_ready), 32'd1);
    check("R1 reg", 32'(reg_rdata), 32'hFF);

    // R2: follow-every-cycle, internal fetches move the pins
    run_req(24'h001234, 1, 0, 0, 0, 8'h00);
    run_req(24'h000100, 0, 1, 0, 0, 8'h00);
    run_req(24'h000102, 0, 1, 0, 0, 8'h00);
    check("R2 internal addr visible", 32'(ext_addr), 32'h000102);

    // R4: switch to external-only
    run_req(CTRL, 0, 0, 1, 0, 8'h00);
    check("R4 mode cleared", 32'(reg_rdata), 32'hFE);

    // R3: external read, then internal fetches keep the address
    run_req(24'h00ABCD, 1, 0, 0, 0, 8'h00);
    run_req(24'h000200, 0, 1, 0, 0, 8'h00);
    run_req(24'h000202, 0, 1, 0, 0, 8'h00);
    check("R3 held across fetches", 32'(ext_addr), 32'h00ABCD);

    // R6: word to 8-bit area, even then odd
    run_req(24'h002001, 1, 1, 0, 1, 8'h00);
    check("R6 ends on odd", 32'(ext_addr), 32'h002001);
    // R7: word to 16-bit area and byte
    run_req(24'h003005, 1, 1, 0, 0, 8'h00);
    check("R7 even single", 32'(ext_addr), 32'h003004);
    run_req(24'h004007, 1, 0, 1, 1, 8'h00);
    check("R7 byte own addr", 32'(ext_addr), 32'h004007);

    // R4: external write to the same address is ignored
    run_req(CTRL, 1, 0, 1, 0, 8'hFF);
    check("R4 external write ignored", 32'(reg_rdata), 32'hFE);
    run_req(CTRL, 0, 0, 1, 0, 8'h01);
    check("R4 mode set", 32'(reg_rdata), 32'hFF);

    // random mix, with mode toggles in between
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      if (a == CTRL) a = a ^ 24'h000100;
      if (i % 100 == 50) run_req(CTRL, 0, 0, 1, 0, 8'($urandom));
      run_req(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule